// File: doc/BRIEF.md
# Dual-Format Serial Audio Input Deserializer

This block takes a stereo serial audio stream carried on three lines and turns it into parallel left and right samples. The lines are a bit clock, a frame-sync level that tells the channel, and serial data. The whole block is clocked by the incoming bit clock. It samples frame sync and data on every rising edge, finds each channel slot from the edges of the frame-sync level, and shifts the slot's bits into a word register, most significant bit first.

A mode input picks one of two framings:
- **I2S-justified:** the left channel is marked by a low frame sync, and the first data bit arrives one bit clock after the frame-sync edge.
- **Left-justified:** the left channel is marked by a high frame sync, and the first data bit arrives together with the edge.

Each finished left/right pair is presented on two registered sample outputs, with a one-cycle valid strobe. The mode is taken during reset and at the start of each left slot. The word width is a parameter.

Top module: `aud_serial_rx`

## Requirements
- R1: With `fmt_lj` = 0 (I2S-justified), a low frame sync marks the left slot and a high frame sync marks the right slot. The first (most significant) bit of a slot is the data bit sampled on the rising edge one bit clock after the edge that first samples the new frame-sync level.
- R2: With `fmt_lj` = 1 (left-justified), a high frame sync marks the left slot and a low frame sync marks the right slot. The first bit of a slot is the data bit sampled on the same rising edge that first samples the new frame-sync level.
- R3: Slot bits fill the output word from bit WORD_W-1 downward. Bits that arrive after WORD_W bits of a slot are discarded, and the count of stored bits never exceeds WORD_W.
- R4: A slot that ends with fewer than WORD_W bits is left-aligned in the output, and its missing low bits read as zero.
- R5: `left_q` and `right_q` update together, and `pair_valid` is high for exactly one cycle. This happens on the rising edge at which the first bit of the next left slot is sampled.
- R6: A slot that was already running when reset ended produces no output. A pair is presented only after a left slot that began at a detected edge, followed by a right slot.
- R7: The mode is loaded while `rst` is high and again at each left-slot start. A change of `fmt_lj` inside a frame does not affect how that frame is decoded; it takes effect from the next left slot on.
- R8: A synchronous, active-high `rst` clears `left_q`, `right_q`, `pair_valid` and the shift register.
- R9: Between valid strobes, `left_q` and `right_q` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fmt_lj | input | 1 | Framing select: 0 I2S-justified, 1 left-justified |
| ws | input | 1 | Frame-sync level giving the channel |
| sd | input | 1 | Serial data, most significant bit first |
| left_q | output | WORD_W | Last completed left sample |
| right_q | output | WORD_W | Last completed right sample |
| pair_valid | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
A finished pair is due on the rising edge that samples the first bit of the next left slot. In left-justified mode that is the same edge at which the frame-sync edge is first seen; in I2S mode it is one bit clock later. The driver records, per pushed pair, the index of that edge, computed from the bits it has driven. The monitor samples on the falling edge and compares the bit-clock count at which `pair_valid` shows against that index, so a strobe that is one cycle early or late is reported as well as a wrong value. A strobe with nothing queued, a second strobe on the following cycle, or a pair still queued after the flush slot and a few idle cycles are each reported as a failure.

// File: rtl/aud_serial_rx_pkg.sv
package aud_serial_rx_pkg;
  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_LJ  = 1'b1
  } fmt_e;
endpackage

// File: rtl/aud_rx_frame_track.sv
// Tracks frame-sync history and reports slot starts for the active framing.
module aud_rx_frame_track
  import aud_serial_rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fmt_i,
  input  logic ws_i,
  output logic slot_start_o,
  output logic start_left_o,
  output fmt_e mode_o
);
  logic       ws_p1_q, ws_p2_q;
  logic [1:0] hist_q;
  fmt_e       mode_q;
  logic       eff_cur, eff_prev, hist_ok;

  // I2S views frame sync one sample late, which yields its one-bit MSB delay.
  always_comb begin
    if (mode_q == FMT_LJ) begin
      eff_cur  = ws_i;
      eff_prev = ws_p1_q;
      hist_ok  = (hist_q != 2'd0);
    end else begin
      eff_cur  = ws_p1_q;
      eff_prev = ws_p2_q;
      hist_ok  = (hist_q == 2'd2);
    end
  end

  assign slot_start_o = hist_ok && (eff_cur != eff_prev);
  assign start_left_o = (mode_q == FMT_LJ) ? eff_cur : ~eff_cur;
  assign mode_o       = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_p1_q <= 1'b0;
      ws_p2_q <= 1'b0;
      hist_q  <= 2'd0;
      mode_q  <= fmt_e'(fmt_i);
    end else begin
      ws_p1_q <= ws_i;
      ws_p2_q <= ws_p1_q;
      if (hist_q != 2'd2) hist_q <= hist_q + 2'd1;
      if (slot_start_o && start_left_o) mode_q <= fmt_e'(fmt_i);
    end
  end
endmodule

// File: rtl/aud_rx_slot_shift.sv
// Collects one channel slot, MSB first, left-aligned, dropping excess bits.
module aud_rx_slot_shift #(
  parameter int W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     slot_start_i,
  input  logic                     start_left_i,
  input  logic                     sd_i,
  output logic                     done_o,
  output logic                     done_left_o,
  output logic [W-1:0]             word_o,
  output logic [$clog2(W+1)-1:0]   cnt_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  sh_q, sh_d;
  logic [CW-1:0] cnt_q;
  logic          armed_q, left_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sh_d[i] = (cnt_q == CW'(W - 1 - i)) ? sd_i : sh_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      left_q  <= 1'b0;
    end else if (slot_start_i) begin
      sh_q    <= {sd_i, {(W-1){1'b0}}};
      cnt_q   <= CW'(1);
      armed_q <= 1'b1;
      left_q  <= start_left_i;
    end else if (armed_q && (cnt_q < CW'(W))) begin
      sh_q    <= sh_d;
      cnt_q   <= cnt_q + CW'(1);
    end
  end

  assign done_o      = slot_start_i & armed_q;
  assign done_left_o = left_q;
  assign word_o      = sh_q;
  assign cnt_o       = cnt_q;
endmodule

// File: rtl/aud_rx_pair_out.sv
// Holds the left word until its right partner completes, then presents both.
module aud_rx_pair_out #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         done_i,
  input  logic         done_left_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);
  logic [W-1:0] hold_q;
  logic         have_left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= '0;
      have_left_q <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done_i) begin
        if (done_left_i) begin
          hold_q      <= word_i;
          have_left_q <= 1'b1;
        end else if (have_left_q) begin
          left_o      <= hold_q;
          right_o     <= word_i;
          valid_o     <= 1'b1;
          have_left_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_serial_rx_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              bclk,
  input  logic              rst,
  input  logic              fmt_lj,
  input  logic              ws,
  input  logic              sd,
  output logic [WORD_W-1:0] left_q,
  output logic [WORD_W-1:0] right_q,
  output logic              pair_valid
);
  localparam int CW = $clog2(WORD_W + 1);

  logic              slot_start, start_left;
  fmt_e              mode_q;
  logic              done, done_left;
  logic [WORD_W-1:0] word;
  logic [CW-1:0]     cnt;

  aud_rx_frame_track u_track (
    .clk          (bclk),
    .rst          (rst),
    .fmt_i        (fmt_lj),
    .ws_i         (ws),
    .slot_start_o (slot_start),
    .start_left_o (start_left),
    .mode_o       (mode_q)
  );

  aud_rx_slot_shift #(.W(WORD_W)) u_shift (
    .clk          (bclk),
    .rst          (rst),
    .slot_start_i (slot_start),
    .start_left_i (start_left),
    .sd_i         (sd),
    .done_o       (done),
    .done_left_o  (done_left),
    .word_o       (word),
    .cnt_o        (cnt)
  );

  aud_rx_pair_out #(.W(WORD_W)) u_out (
    .clk         (bclk),
    .rst         (rst),
    .done_i      (done),
    .done_left_i (done_left),
    .word_i      (word),
    .left_o      (left_q),
    .right_o     (right_q),
    .valid_o     (pair_valid)
  );
endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
  parameter int W = 24
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   pair_valid,
  input logic [W-1:0]           left_q,
  input logic [W-1:0]           right_q,
  input logic                   slot_start,
  input logic                   start_left,
  input logic                   mode_lj,
  input logic [$clog2(W+1)-1:0] cnt
);
  localparam int CW = $clog2(W + 1);

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> !pair_valid);

  a_r5_strobe_follows_left_start: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> $past(slot_start && start_left));

  a_r9_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
    !pair_valid |-> ($stable(left_q) && $stable(right_q)));

  a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (left_q == '0 && right_q == '0 && !pair_valid));

  a_r7_mode_at_boundary: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$stable(mode_lj)) |-> $past(slot_start && start_left));

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(W));
endmodule

bind aud_serial_rx aud_serial_rx_chk #(.W(WORD_W)) u_chk (
  .clk        (bclk),
  .rst        (rst),
  .pair_valid (pair_valid),
  .left_q     (left_q),
  .right_q    (right_q),
  .slot_start (slot_start),
  .start_left (start_left),
  .mode_lj    (mode_q),
  .cnt        (cnt)
);

// File: tb/aud_serial_rx_test.sv
module aud_serial_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;

  logic         bclk = 1'b0;
  logic         rst = 1'b1;
  logic         fmt_lj = 1'b0;
  logic         ws = 1'b0;
  logic         sd = 1'b0;
  logic [W-1:0] left_q, right_q;
  logic         pair_valid;

  aud_serial_rx #(.WORD_W(W)) uut (
    .bclk(bclk), .rst(rst), .fmt_lj(fmt_lj), .ws(ws), .sd(sd),
    .left_q(left_q), .right_q(right_q), .pair_valid(pair_valid)
  );

  always #(CLK_PERIOD/2) bclk = ~bclk;

  typedef struct {
    logic [W-1:0] l;
    logic [W-1:0] r;
    int           due;
    string        tag;
  } exp_t;

  exp_t         sbq[$];
  exp_t         mon_e;
  int           checks = 0;
  int           failures = 0;
  int           cyc = 0;
  int           drv_cyc = 0;
  int           vcount = 0;
  logic         prev_v = 1'b0;
  logic         lag = 1'b0;
  logic         pending = 1'b0;
  logic [W-1:0] pl, pr;
  string        ptag;
  logic [W-1:0] last_l = '0, last_r = '0;

  always @(posedge bclk) cyc <= cyc + 1;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] keep_mask(input int len);
    if (len >= W) return '1;
    return ~({W{1'b1}} >> len);
  endfunction

  // Scoreboard monitor: sampled on the falling edge, away from the active edge.
  always @(negedge bclk) begin
    if (rst) begin
      prev_v = 1'b0;
    end else begin
      if (pair_valid) begin
        vcount++;
        if (prev_v) chk("R5 strobe longer than one cycle", 1, 0);
        if (sbq.size() == 0) begin
          chk("R6 unexpected pair", 1, 0);
        end else begin
          mon_e = sbq.pop_front();
          chk({mon_e.tag, " left"}, left_q, mon_e.l);
          chk({mon_e.tag, " right"}, right_q, mon_e.r);
          chk("R5 strobe cycle", cyc, mon_e.due);
          last_l = mon_e.l;
          last_r = mon_e.r;
        end
      end
      prev_v = pair_valid;
    end
  end

  task automatic drive_bit(input logic w, input logic d);
    @(negedge bclk);
    ws = w;
    sd = d;
    drv_cyc = cyc + 1;
  endtask

  task automatic send_slot(input logic lj, input logic left, input logic [W-1:0] word,
                           input int len, input logic pad, input int flip_at);
    for (int j = 0; j < len; j++) begin
      logic b;
      logic wlev;
      b = pad;
      if (j < W) b = word[W-1-j];
      if (j == flip_at) fmt_lj = ~fmt_lj;
      wlev = lj ? left : ~left;
      if (lj) drive_bit(wlev, b);
      else begin
        drive_bit(wlev, lag);
        lag = b;
      end
      if (j == 0 && left && pending) begin
        sbq.push_back('{pl, pr, drv_cyc + (lj ? 0 : 1), ptag});
        pending = 1'b0;
      end
    end
  endtask

  task automatic send_frame(input logic lj, input logic [W-1:0] l, input logic [W-1:0] r,
                            input int len, input logic pad, input string tag, input int flip_at);
    send_slot(lj, 1'b1, l, len, pad, flip_at);
    send_slot(lj, 1'b0, r, len, pad, -1);
    pending = 1'b1;
    pl = l & keep_mask(len);
    pr = r & keep_mask(len);
    ptag = tag;
  endtask

  task automatic flush(input logic lj);
    send_slot(lj, 1'b1, '0, 4, 1'b0, -1);
    repeat (3) @(negedge bclk);
    chk("R5 all expected pairs delivered", sbq.size(), 0);
    chk("R9 left held after strobe", left_q, last_l);
    chk("R9 right held after strobe", right_q, last_r);
  endtask

  task automatic start_test(input logic lj, input logic ws_init);
    rst = 1'b1;
    fmt_lj = lj;
    ws = ws_init;
    sd = 1'b0;
    lag = 1'b0;
    pending = 1'b0;
    repeat (3) @(negedge bclk);
    chk("R8 reset clears left", left_q, 0);
    chk("R8 reset clears right", right_q, 0);
    chk("R8 reset clears strobe", pair_valid, 0);
    last_l = '0;
    last_r = '0;
    rst = 1'b0;
  endtask

  initial begin
    int v0;
    // I2S-justified framing (R1), long slots (R3), short slots (R4)
    start_test(1'b0, 1'b1);
    send_slot(1'b0, 1'b0, 24'h0, 3, 1'b0, -1);
    send_frame(1'b0, 24'hA5C3F1, 24'h5A3C0E, 24, 1'b0, "R1 i2s", -1);
    send_frame(1'b0, 24'h800001, 24'h7FFFFE, 24, 1'b0, "R1 i2s edge bits", -1);
    send_frame(1'b0, 24'hFFFFFF, 24'h000000, 24, 1'b0, "R1 i2s extremes", -1);
    send_frame(1'b0, 24'h123456, 24'hFEDCBA, 32, 1'b1, "R3 i2s long slot", -1);
    send_frame(1'b0, 24'hABCDEF, 24'h13579B, 16, 1'b0, "R4 i2s short slot", -1);
    flush(1'b0);

    // Left-justified framing (R2), also reset after nonzero outputs (R8)
    start_test(1'b1, 1'b0);
    send_slot(1'b1, 1'b0, 24'h0, 3, 1'b0, -1);
    send_frame(1'b1, 24'hC0FFEE, 24'h0BADF0, 24, 1'b0, "R2 lj", -1);
    send_frame(1'b1, 24'h000001, 24'h800000, 24, 1'b0, "R2 lj edge bits", -1);
    send_frame(1'b1, 24'h654321, 24'h9ABCDE, 30, 1'b1, "R3 lj long slot", -1);
    send_frame(1'b1, 24'hF0F0F0, 24'h0F0F0F, 8, 1'b0, "R4 lj short slot", -1);
    flush(1'b1);

    // Stream already inside a left slot when reset ends (R6)
    start_test(1'b1, 1'b1);
    v0 = vcount;
    send_slot(1'b1, 1'b1, 24'hDEAD01, 10, 1'b0, -1);
    send_slot(1'b1, 1'b0, 24'hBEEF02, 24, 1'b0, -1);
    send_frame(1'b1, 24'h314159, 24'h271828, 24, 1'b0, "R6 first full frame", -1);
    flush(1'b1);
    chk("R6 only complete frames produce pairs", vcount - v0, 1);

    // Mode change inside a frame applies from the next left slot (R7)
    start_test(1'b0, 1'b1);
    send_slot(1'b0, 1'b0, 24'h0, 3, 1'b0, -1);
    send_frame(1'b0, 24'h111111, 24'h222222, 24, 1'b0, "R7 before change", -1);
    send_frame(1'b0, 24'h3C3C3C, 24'hC3C3C3, 24, 1'b0, "R7 frame with mid change", 5);
    flush(1'b0);
    send_frame(1'b1, 24'h456789, 24'h987654, 24, 1'b0, "R7 new mode applied", -1);
    send_frame(1'b1, 24'hAAAAAA, 24'h555555, 24, 1'b0, "R7 new mode applied", -1);
    flush(1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge bclk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule